// File: doc/BRIEF.md
# Host-Bus Pixel Unpacker

This block sits behind a parallel host write port of the 8080 kind and turns a stream of bus writes into complete 18-bit pixels for a frame-buffer write port. Each write carries a command/data flag. Command writes carry no pixel content. They only return the unpacker to the start of a pixel. Data writes deliver colour components, and how they are sliced depends on the bus format chosen on the `mode` input.

Three formats are supported:

- **Narrow format.** A byte-wide bus delivers one colour per write, so a pixel takes three writes.
- **16-bit 565 format.** A 16-bit word delivers a whole 565 pixel in one write, which is widened to six bits per colour.
- **16-bit 666 format.** A 16-bit word carries two colour fields, so three writes deliver two pixels. In this format the colour boundaries cross word boundaries, and a phase machine tracks where the next field belongs.

Every completed pixel is presented for a single clock together with a valid strobe.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, `px_valid` is 0 and the colour phase is at its first position. The first three narrow-format data writes therefore form one pixel.
- R2: Narrow format (`mode`=2'b00) works as follows. Three data writes in a row supply red, then green, then blue, each taken from bus bits 7:2. The pixel appears only after the third write. Output layout is red in `px_data[17:12]`, green in 11:6 and blue in 5:0.
- R3: In narrow format, bus bits 15:8 and 1:0 have no effect on the pixel.
- R4: In 565 format (`mode`=2'b11), every data write produces one pixel. Red comes from bus bits 15:11, green from 10:5 and blue from 4:0.
- R5: In 565 format, the five-bit red and blue fields are widened to six bits. The field MSB is copied into the new LSB, and green passes through unchanged.
- R6: In 666 format (`mode`=2'b10), three data writes give two pixels, with each colour taken from bits 15:10 or 7:2 of a word:
  - The first write carries red of pixel A in 15:10 and green of pixel A in 7:2.
  - The second write carries blue of pixel A in 15:10 and red of pixel B in 7:2. Pixel A is emitted after the second write.
  - The third write carries green of pixel B in 15:10 and blue of pixel B in 7:2. Pixel B is emitted after the third write.
- R7: In 666 format, bus bits 9:8 and 1:0 have no effect.
- R8: A command write (`dc`=0) produces no pixel, and it returns the colour phase to the first component of a pixel in every format.
- R9: `px_valid` is high for exactly one clock, in the cycle that follows the write that delivers the last component of a pixel.
- R10: Without a write strobe, `px_valid` stays 0, whatever the bus and `dc` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe from the host bus |
| dc | input | 1 | 0 = command write, 1 = parameter/pixel data write |
| bus_data | input | 16 | Host data bus |
| mode | input | 2 | Bus format: 00 narrow, 11 16-bit 565, 10 16-bit 666 (01 behaves as narrow) |
| px_valid | output | 1 | One-clock strobe marking a completed pixel |
| px_data | output | 18 | Completed pixel, {red, green, blue}, six bits each |

## Verification
The assertions check several properties on every clock:
- the strobe appears only in the cycle after a data write;
- it never follows a command write or an idle cycle;
- the 565 green field and MSB replication hold;
- the narrow-format blue field comes from the final byte.

Three properties depend on write history that spans several bus cycles, so only the bench scenarios can show them:
- assembling components across writes;
- the two-pixel straddle of the 666 format;
- the phase reset by a command in the middle of a pixel.

// File: rtl/pixel_unpacker.sv
module pixel_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic        dc,
  input  logic [15:0] bus_data,
  input  logic [1:0]  mode,
  output logic        px_valid,
  output logic [17:0] px_data
);
  localparam logic [1:0] MODE_565 = 2'b11;
  localparam logic [1:0] MODE_666 = 2'b10;

  logic [1:0] phase;
  logic [5:0] hold_a, hold_b;
  logic [5:0] hi6, lo6;

  assign hi6 = bus_data[15:10];
  assign lo6 = bus_data[7:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= 2'd0;
      hold_a   <= '0;
      hold_b   <= '0;
      px_valid <= 1'b0;
      px_data  <= '0;
    end else begin
      px_valid <= 1'b0;
      if (wr_stb && !dc) begin
        phase <= 2'd0;
      end else if (wr_stb) begin
        case (mode)
          MODE_565: begin
            px_valid <= 1'b1;
            px_data  <= {bus_data[15:11], bus_data[15], bus_data[10:5],
                         bus_data[4:0], bus_data[4]};
            phase    <= 2'd0;
          end
          MODE_666: begin
            case (phase)
              2'd0: begin
                hold_a <= hi6;
                hold_b <= lo6;
                phase  <= 2'd1;
              end
              2'd1: begin
                px_valid <= 1'b1;
                px_data  <= {hold_a, hold_b, hi6};
                hold_a   <= lo6;
                phase    <= 2'd2;
              end
              default: begin
                px_valid <= 1'b1;
                px_data  <= {hold_a, hi6, lo6};
                phase    <= 2'd0;
              end
            endcase
          end
          default: begin
            case (phase)
              2'd0: begin
                hold_a <= lo6;
                phase  <= 2'd1;
              end
              2'd1: begin
                hold_b <= lo6;
                phase  <= 2'd2;
              end
              default: begin
                px_valid <= 1'b1;
                px_data  <= {hold_a, hold_b, lo6};
                phase    <= 2'd0;
              end
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_stb,
  input logic        dc,
  input logic [15:0] bus_data,
  input logic [1:0]  mode,
  input logic        px_valid,
  input logic [17:0] px_data
);
  p_pulse_after_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> $past(wr_stb && dc));

  p_cmd_no_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stb && !dc) |-> !px_valid);

  p_idle_no_pixel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> !px_valid);

  p_green_565_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && $past(mode) == 2'b11) |-> px_data[11:6] == $past(bus_data[10:5]));

  p_msb_copy_565_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && $past(mode) == 2'b11) |-> (px_data[12] == px_data[17] && px_data[0] == px_data[5]));

  p_blue_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && $past(mode) == 2'b00) |-> px_data[5:0] == $past(bus_data[7:2]));
endmodule

bind pixel_unpacker pixel_unpacker_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .dc(dc), .bus_data(bus_data),
  .mode(mode), .px_valid(px_valid), .px_data(px_data)
);

// File: tb/tb_pixel_unpacker.sv
module tb_pixel_unpacker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic        dc = 1'b0;
  logic [15:0] bus_data = '0;
  logic [1:0]  mode = 2'b00;
  logic        px_valid;
  logic [17:0] px_data;

  int checks = 0;
  int errors = 0;
  logic        got_v;
  logic [17:0] got_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_unpacker dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .dc(dc), .bus_data(bus_data),
    .mode(mode), .px_valid(px_valid), .px_data(px_data)
  );

  task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic d_c, input logic [15:0] w);
    @(negedge clk);
    dc = d_c; bus_data = w; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    got_v = px_valid;
    got_d = px_data;
  endtask

  function automatic logic [17:0] exp565(input logic [15:0] w);
    return {w[15:11], w[15], w[10:5], w[4:0], w[4]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(px_valid == 1'b0, "R1 reset valid", {17'd0, px_valid}, 18'd0);

    // R1/R2/R3/R9: narrow sweep with junk in ignored bits
    mode = 2'b00;
    for (int i = 0; i < 64; i++) begin
      logic [5:0] r, g, b;
      logic [17:0] e;
      r = 6'(i); g = 6'(i * 5 + 3); b = 6'(i * 11 + 7);
      e = {r, g, b};
      wr(1'b1, {8'(i * 37), r, 2'(i)});
      check(got_v == 1'b0, "R2 no pixel after red", {17'd0, got_v}, 18'd0);
      wr(1'b1, {8'(~i), g, 2'(~i)});
      check(got_v == 1'b0, "R2 no pixel after green", {17'd0, got_v}, 18'd0);
      wr(1'b1, {8'(i * 91), b, 2'(i + 1)});
      check(got_v == 1'b1 && got_d == e, "R3 narrow pixel", got_d, e);
      @(negedge clk);
      check(px_valid == 1'b0, "R9 one clock pulse", {17'd0, px_valid}, 18'd0);
    end

    // R10: bus and dc change with no strobe
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      dc = i[0]; bus_data = 16'(i * 4099);
      @(negedge clk);
      check(px_valid == 1'b0, "R10 no strobe no pixel", {17'd0, px_valid}, 18'd0);
    end

    // R8: command mid-pixel in narrow format
    wr(1'b1, 16'h00fc);
    wr(1'b1, 16'h0040);
    wr(1'b0, 16'h002c);
    check(got_v == 1'b0, "R8 command gives no pixel", {17'd0, got_v}, 18'd0);
    wr(1'b1, 16'h0004);
    wr(1'b1, 16'h0008);
    wr(1'b1, 16'h000c);
    check(got_v == 1'b1 && got_d == {6'd1, 6'd2, 6'd3}, "R8 narrow restart", got_d, {6'd1, 6'd2, 6'd3});

    // R4/R5: 565 sweep
    mode = 2'b11;
    for (int i = 0; i < 512; i++) begin
      logic [15:0] w;
      w = 16'(i * 2731 + i / 3);
      wr(1'b1, w);
      check(got_v == 1'b1 && got_d == exp565(w), "R4 R5 565 pixel", got_d, exp565(w));
    end
    wr(1'b1, 16'hffff);
    check(got_d == 18'h3ffff, "R5 565 all ones", got_d, 18'h3ffff);
    wr(1'b1, 16'h0000);
    check(got_d == 18'h00000, "R5 565 all zeros", got_d, 18'h00000);

    // R6/R7: 666 sweep with junk in ignored bits
    mode = 2'b10;
    wr(1'b0, 16'h002c);
    for (int i = 0; i < 64; i++) begin
      logic [5:0] ra, ga, ba, rb, gb, bb;
      ra = 6'(i); ga = 6'(i * 3 + 1); ba = 6'(i * 7 + 2);
      rb = 6'(i * 13 + 5); gb = 6'(~i); bb = 6'(i * 29 + 9);
      wr(1'b1, {ra, 2'(i), ga, 2'(i + 2)});
      check(got_v == 1'b0, "R6 no pixel after word 1", {17'd0, got_v}, 18'd0);
      wr(1'b1, {ba, 2'(~i), rb, 2'(i * 3)});
      check(got_v == 1'b1 && got_d == {ra, ga, ba}, "R7 666 pixel A", got_d, {ra, ga, ba});
      wr(1'b1, {gb, 2'(i + 1), bb, 2'(~i)});
      check(got_v == 1'b1 && got_d == {rb, gb, bb}, "R7 666 pixel B", got_d, {rb, gb, bb});
    end

    // R8: command after word 2 in 666
    wr(1'b1, {6'd10, 2'b00, 6'd11, 2'b00});
    wr(1'b1, {6'd12, 2'b00, 6'd13, 2'b00});
    wr(1'b0, 16'h0000);
    check(got_v == 1'b0, "R8 command in 666", {17'd0, got_v}, 18'd0);
    wr(1'b1, {6'd20, 2'b11, 6'd21, 2'b11});
    check(got_v == 1'b0, "R8 666 restart word 1", {17'd0, got_v}, 18'd0);
    wr(1'b1, {6'd22, 2'b11, 6'd23, 2'b11});
    check(got_v == 1'b1 && got_d == {6'd20, 6'd21, 6'd22}, "R8 666 restart pixel", got_d, {6'd20, 6'd21, 6'd22});

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule